// File: doc/BRIEF.md
# Bridge Bus-Number Range Decoder

This block makes the routing decision for configuration requests that arrive on the primary side of a PCI-to-PCI bridge. It holds the bridge's primary, secondary and subordinate bus numbers and its 16-bit bridge control word. For every request it compares the target bus number against the secondary and subordinate numbers. One clock later it reports one of three outcomes:

- convert the request to type 0 and hand it to the directly attached bus;
- pass it on unchanged as type 1 for a bus further downstream;
- leave it unclaimed.

While the control word holds the secondary bus in reset, the block drives a reset output to that bus and claims nothing. The control word keeps a discard-timer status flag. An external timeout pulse sets the flag, and software clears it by writing a one.

Top module: `br_bus_decoder`

## Requirements
- R1: After reset, all three bus-number registers and the control word read as zero, `dec_valid` is low and `sec_reset` is low.
- R2: `cfg_sel` selects the register for both write and read: 0 is the primary bus number, 1 the secondary, 2 the subordinate, and 3 the control word. A write with `cfg_wr` high loads the full 8-bit bus number from `cfg_wdata[7:0]`. Reads of bus numbers return zero in bits 15:8.
- R3: Control-word bits 0 to 9 and bit 11 are read/write. Bits 12 to 15 always read as zero.
- R4: Control bit 10 is the discard status flag. A `discard_tmo` pulse sets it. A control write with bit 10 set clears it, and a write with bit 10 clear leaves it unchanged. When a set and a clear fall in the same cycle, the set wins.
- R5: A request whose bus equals the secondary number yields `dec_kind` = 1 (claim, convert to type 0).
- R6: A request whose bus is strictly greater than the secondary number and no greater than the subordinate number yields `dec_kind` = 2 (claim, forward as type 1).
- R7: Every other bus number yields `dec_kind` = 0 (no claim). This includes every bus when the subordinate number is below the secondary.
- R8: While control bit 6 (secondary bus reset) is set, every request yields `dec_kind` = 0, including one for the secondary bus itself.
- R9: `sec_reset` equals control bit 6 in the same cycle, with no added register.
- R10: `dec_valid` is high exactly in the cycle after a cycle with `req_valid` high. `dec_kind` is built from the register values present in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for write and read |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data of the selected register |
| discard_tmo | input | 1 | Pulse that sets the discard status flag |
| req_valid | input | 1 | Configuration request present |
| req_bus | input | 8 | Target bus number of the request |
| dec_valid | output | 1 | Decision valid (one cycle after the request) |
| dec_kind | output | 2 | 0 no claim, 1 type-0 local, 2 type-1 downstream |
| sec_reset | output | 1 | Reset driven to the secondary bus |

## Verification
A corrupted secondary or subordinate register moves the claim boundaries. The fault shows on `dec_kind` one cycle after the first request whose bus crosses the wrong edge. Because the bench sweeps every bus number for each configuration, one sweep exposes it. A stuck reset bit either lets claims through during reset or suppresses every claim, and `sec_reset` disagrees with the read-back control word in the same cycle. A wrong write policy on the control word shows up on the next read of that register.

// File: rtl/br_pkg.sv
package br_pkg;
   typedef enum logic [1:0] {
      FWD_NONE  = 2'd0,
      FWD_LOCAL = 2'd1,
      FWD_DOWN  = 2'd2
   } fwd_kind_e;

   localparam int SEL_PRI = 0;
   localparam int SEL_SEC = 1;
   localparam int SEL_SUB = 2;
   localparam int SEL_CTL = 3;
endpackage

// File: rtl/br_busnum_regs.sv
module br_busnum_regs #(
   parameter int BUS_W = 8,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [BUS_W-1:0] wr_val,
   output logic [BUS_W-1:0] pri_num,
   output logic [BUS_W-1:0] sec_num,
   output logic [BUS_W-1:0] sub_num
);
   localparam int NUM_REGS = 3;

   logic [BUS_W-1:0] num_q [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_num
      always_ff @(posedge clk) begin
         if (!rst_n)
            num_q[i] <= '0;
         else if (wr_en && (wr_sel == SEL_W'(i)))
            num_q[i] <= wr_val;
      end
   end

   assign pri_num = num_q[br_pkg::SEL_PRI];
   assign sec_num = num_q[br_pkg::SEL_SEC];
   assign sub_num = num_q[br_pkg::SEL_SUB];

   p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_W'(br_pkg::SEL_SEC)) |=> (sec_num == $past(wr_val)));
endmodule

// File: rtl/br_ctrl_reg.sv
module br_ctrl_reg #(
   parameter int             CTRL_W   = 16,
   parameter logic [CTRL_W-1:0] RW_MASK  = 16'h0FFF,
   parameter logic [CTRL_W-1:0] W1C_MASK = 16'h0400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_val,
   input  logic [CTRL_W-1:0] hw_set,
   output logic [CTRL_W-1:0] ctrl
);
   for (genvar b = 0; b < CTRL_W; b++) begin : g_bit
      if (W1C_MASK[b]) begin : g_w1c
         always_ff @(posedge clk) begin
            if (!rst_n)
               ctrl[b] <= 1'b0;
            else if (hw_set[b])
               ctrl[b] <= 1'b1;
            else if (wr_en && wr_val[b])
               ctrl[b] <= 1'b0;
         end
      end else if (RW_MASK[b]) begin : g_rw
         always_ff @(posedge clk) begin
            if (!rst_n)
               ctrl[b] <= 1'b0;
            else if (wr_en)
               ctrl[b] <= wr_val[b];
         end
      end else begin : g_ro
         assign ctrl[b] = 1'b0;
      end
   end

   for (genvar b = 0; b < CTRL_W; b++) begin : g_chk
      if (W1C_MASK[b]) begin : g_w1c_chk
         p_w1c_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_val[b] && !hw_set[b]) |=> !ctrl[b]);
         p_w1c_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl[b] && !(wr_en && wr_val[b])) |=> ctrl[b]);
      end
   end
endmodule

// File: rtl/br_range_cmp.sv
module br_range_cmp #(
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [BUS_W-1:0] req_bus,
   input  logic [BUS_W-1:0] sec_num,
   input  logic [BUS_W-1:0] sub_num,
   input  logic             hold,
   output logic             dec_valid,
   output logic [1:0]       dec_kind
);
   import br_pkg::*;

   logic      hit_local;
   logic      hit_down;
   fwd_kind_e kind_d;

   always_comb begin
      hit_local = (req_bus == sec_num);
      hit_down  = (req_bus > sec_num) && (req_bus <= sub_num);
      if (hold)
         kind_d = FWD_NONE;
      else if (hit_local)
         kind_d = FWD_LOCAL;
      else if (hit_down)
         kind_d = FWD_DOWN;
      else
         kind_d = FWD_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         dec_kind  <= FWD_NONE;
      end else begin
         dec_valid <= req_valid;
         if (req_valid)
            dec_kind <= kind_d;
      end
   end

   p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> dec_valid);
   p_valid_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !dec_valid);
   p_hold_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && hold) |=> (dec_kind == FWD_NONE));
   p_local_claim_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !hold && req_bus == sec_num) |=> (dec_kind == FWD_LOCAL));
endmodule

// File: rtl/br_bus_decoder.sv
module br_bus_decoder #(
   parameter int                BUS_W     = 8,
   parameter int                CTRL_W    = 16,
   parameter int                RST_BIT   = 6,
   parameter int                DSTAT_BIT = 10,
   parameter logic [CTRL_W-1:0] RW_MASK   = 16'h0FFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [CTRL_W-1:0] cfg_wdata,
   output logic [CTRL_W-1:0] cfg_rdata,
   input  logic              discard_tmo,
   input  logic              req_valid,
   input  logic [BUS_W-1:0]  req_bus,
   output logic              dec_valid,
   output logic [1:0]        dec_kind,
   output logic              sec_reset
);
   import br_pkg::*;

   localparam logic [CTRL_W-1:0] W1C_MASK = CTRL_W'(1) << DSTAT_BIT;

   if (CTRL_W < BUS_W) begin : g_bad_width
      $error("control width must cover a bus number");
   end
   if (RST_BIT >= CTRL_W || DSTAT_BIT >= CTRL_W) begin : g_bad_bit
      $error("control bit position out of range");
   end

   logic [BUS_W-1:0]  pri_num, sec_num, sub_num;
   logic [CTRL_W-1:0] ctrl;
   logic [CTRL_W-1:0] hw_set;
   logic              bus_wr, ctl_wr;

   assign bus_wr = cfg_wr && (cfg_sel != 2'(SEL_CTL));
   assign ctl_wr = cfg_wr && (cfg_sel == 2'(SEL_CTL));
   assign hw_set = CTRL_W'(discard_tmo) << DSTAT_BIT;

   br_busnum_regs #(.BUS_W(BUS_W), .SEL_W(2)) u_nums (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr),
      .wr_sel  (cfg_sel),
      .wr_val  (cfg_wdata[BUS_W-1:0]),
      .pri_num (pri_num),
      .sec_num (sec_num),
      .sub_num (sub_num)
   );

   br_ctrl_reg #(.CTRL_W(CTRL_W), .RW_MASK(RW_MASK), .W1C_MASK(W1C_MASK)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (ctl_wr),
      .wr_val (cfg_wdata),
      .hw_set (hw_set),
      .ctrl   (ctrl)
   );

   assign sec_reset = ctrl[RST_BIT];

   br_range_cmp #(.BUS_W(BUS_W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_bus   (req_bus),
      .sec_num   (sec_num),
      .sub_num   (sub_num),
      .hold      (sec_reset),
      .dec_valid (dec_valid),
      .dec_kind  (dec_kind)
   );

   always_comb begin
      unique case (cfg_sel)
         2'(SEL_PRI): cfg_rdata = CTRL_W'(pri_num);
         2'(SEL_SEC): cfg_rdata = CTRL_W'(sec_num);
         2'(SEL_SUB): cfg_rdata = CTRL_W'(sub_num);
         default:     cfg_rdata = ctrl;
      endcase
   end

   p_tmo_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      discard_tmo |=> ctrl[DSTAT_BIT]);
endmodule

// File: tb/tb_br_bus_decoder.sv
module tb_br_bus_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        discard_tmo = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_bus = '0;
   logic        dec_valid;
   logic [1:0]  dec_kind;
   logic        sec_reset;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   br_bus_decoder dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .discard_tmo(discard_tmo),
      .req_valid(req_valid), .req_bus(req_bus), .dec_valid(dec_valid),
      .dec_kind(dec_kind), .sec_reset(sec_reset)
   );

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(int sel, int val);
      cfg_wr = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 16'(val);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd_check(string req, int sel, int exp);
      cfg_sel = 2'(sel);
      #1;
      check(req, int'(cfg_rdata), exp);
   endtask

   function automatic int expect_kind(int bus, int sec, int sub, bit rst);
      if (rst) return 0;
      if (bus == sec) return 1;
      if (bus > sec && bus <= sub) return 2;
      return 0;
   endfunction

   task automatic sweep(int sec, int sub, bit rst);
      int tag;
      wr(1, sec);
      wr(2, sub);
      wr(3, rst ? 16'h0040 : 16'h0000);
      for (int b = 0; b < 256; b++) begin
         req_valid = 1'b1; req_bus = 8'(b);
         @(negedge clk);
         tag = expect_kind(b, sec, sub, rst);
         check("R10", int'(dec_valid), 1);
         if (rst)            check("R8", int'(dec_kind), tag);
         else if (tag == 1)  check("R5", int'(dec_kind), tag);
         else if (tag == 2)  check("R6", int'(dec_kind), tag);
         else                check("R7", int'(dec_kind), tag);
      end
      req_valid = 1'b0;
      @(negedge clk);
      check("R10 idle", int'(dec_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 valid", int'(dec_valid), 0);
      check("R1 secrst", int'(sec_reset), 0);
      for (int s = 0; s < 4; s++) rd_check("R1", s, 0);

      // R2 bus number registers
      wr(0, 16'hFFA5); rd_check("R2 pri", 0, 16'h00A5);
      wr(1, 16'h003C); rd_check("R2 sec", 1, 16'h003C);
      wr(2, 16'h12FF); rd_check("R2 sub", 2, 16'h00FF);
      rd_check("R2 pri kept", 0, 16'h00A5);

      // R3, R4, R9 control word
      wr(3, 16'hFFFF);
      rd_check("R3 mask", 3, 16'h0BFF);
      check("R9 on", int'(sec_reset), 1);
      wr(3, 16'h0000);
      rd_check("R3 zero", 3, 0);
      check("R9 off", int'(sec_reset), 0);
      wr(3, 16'h0040);
      check("R9 bit6", int'(sec_reset), 1);
      rd_check("R3 bit6", 3, 16'h0040);
      wr(3, 16'h0000);
      discard_tmo = 1'b1; @(negedge clk); discard_tmo = 1'b0;
      rd_check("R4 set", 3, 16'h0400);
      wr(3, 16'h0003);
      rd_check("R4 write0 keeps", 3, 16'h0403);
      wr(3, 16'h0400);
      rd_check("R4 write1 clears", 3, 16'h0000);
      discard_tmo = 1'b1; cfg_wr = 1'b1; cfg_sel = 2'd3; cfg_wdata = 16'h0400;
      @(negedge clk);
      discard_tmo = 1'b0; cfg_wr = 1'b0;
      rd_check("R4 set wins", 3, 16'h0400);
      wr(3, 16'h0400);

      // R5-R8, R10 sweeps
      sweep(5, 20, 0);
      sweep(5, 20, 1);
      sweep(0, 255, 0);
      sweep(255, 255, 0);
      sweep(40, 10, 0);
      sweep(7, 7, 0);
      sweep(0, 0, 1);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            bad++; total++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule